// File: doc/BRIEF.md
# Qualified Edge Event Down-Counter

This block counts transitions on an asynchronous input pin. A software-style control interface loads a start value and a target (match) value. A one-cycle enable pulse then arms the counter. Each qualified transition on the pin reduces the count by one. The qualifying transitions are rising, falling or both, as chosen by a two-bit selector. When a decrement would land on the match value, the block does three things: it sets a sticky raw status flag, it reloads the start value, and it disarms itself. The number of transitions counted per run is therefore the start value minus the match value, taken modulo 2^16.

The pin goes through a two-stage synchronizer. A transition is accepted only when the new level is seen on two consecutive samples. A one-cycle glitch is therefore dropped, and the highest input rate that is reliably counted is one quarter of the clock. The raw flag is cleared by a write-one pulse. A mask input gates a masked copy of the flag, which serves as the interrupt line.

Top module: `edge_event_counter`

## Requirements
- R1: After synchronous reset the count is 0, the counter is disarmed, and the raw and masked flags are 0.
- R2: A pin level is accepted only when it is held for two consecutive samples after a change. A one-cycle pulse is never counted, and a two-cycle pulse is counted. The decrement is visible after the fifth rising clock edge, counting the first edge that samples the new level as the first.
- R3: Edge selector encoding: 2'b00 counts rising transitions only, 2'b01 counts falling transitions only, and 2'b10 or 2'b11 counts both.
- R4: While armed, each qualified transition reduces the count by exactly one, wrapping modulo 2^16.
- R5: A one-cycle enable pulse loads the count with the start value and arms the counter. This happens even when the counter is already armed, and it overrides any decrement in the same cycle.
- R6: When a decrement would make the count equal the match value, the count instead reloads the start value and the counter disarms. This happens after (start − match) transitions.
- R7: Transitions that arrive while the counter is disarmed leave the count unchanged.
- R8: The raw flag is set on a match and then holds until a clear pulse. A match in the same cycle as a clear leaves the flag set.
- R9: The masked flag equals the raw flag ANDed with the mask. It updates together with the raw flag, and one clock after a change of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous event input |
| en_set | input | 1 | One-cycle pulse: load start value and arm |
| edge_sel | input | 2 | Edge selector (00 rise, 01 fall, 1x both) |
| load_val | input | 16 | Start value |
| match_val | input | 16 | Match value |
| irq_mask | input | 1 | 1 lets the raw flag through to the masked flag |
| irq_clr | input | 1 | Write-one-to-clear pulse for the raw flag |
| count_o | output | 16 | Current count |
| enabled_o | output | 1 | Counter armed |
| raw_match_o | output | 1 | Sticky match flag |
| masked_match_o | output | 1 | Raw flag gated by mask |

## Verification
Two functions can fall in the same clock edge. First, a match can set the raw flag while a clear pulse is asserted. Second, an enable pulse can reload the count while an event is being applied. The bench holds the clear input high across the edge where the final qualified transition lands. It then expects the raw flag to read 1 right after that edge and 0 one edge later. Separately, it arms the counter in the middle of a run and expects the new start value with no decrement applied. A behavioural model keeps a history of pin samples and is compared with every output on every clock.

// File: rtl/eec_pkg.sv
package eec_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/eec_sync.sv
module eec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/eec_edge_qual.sv
module eec_edge_qual
  import eec_pkg::*;
#(
  parameter int HOLD = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  logic [1:0] edge_sel,
  output logic       evt
);
  localparam int HW = HOLD + 1;

  logic [HW-1:0] hist;
  logic          rise, fall;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[HW-2:0], lvl};
  end

  // oldest sample opposite, HOLD newer samples at the new level
  assign rise = ~hist[HW-1] &  (&hist[HOLD-1:0]);
  assign fall =  hist[HW-1] & ~(|hist[HOLD-1:0]);

  always_comb begin
    case (edge_mode_e'(edge_sel))
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      default:   evt = rise | fall;
    endcase
  end
endmodule

// File: rtl/eec_core.sv
module eec_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_set,
  input  logic             evt,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] count,
  output logic             enabled,
  output logic             hit
);
  logic [CNT_W-1:0] dec;

  assign dec = count - CNT_W'(1);
  assign hit = enabled & evt & (dec == match_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      enabled <= 1'b0;
    end else if (en_set) begin
      count   <= load_val;
      enabled <= 1'b1;
    end else if (hit) begin
      count   <= load_val;
      enabled <= 1'b0;
    end else if (enabled && evt) begin
      count   <= dec;
    end
  end
endmodule

// File: rtl/edge_event_counter.sv
module edge_event_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_HOLD   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_in,
  input  logic             en_set,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  input  logic             irq_mask,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             enabled_o,
  output logic             raw_match_o,
  output logic             masked_match_o
);
  logic pin_sync;
  logic evt_w;
  logic hit_w;
  logic raw_nxt;

  eec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(pin_sync)
  );

  eec_edge_qual #(.HOLD(QUAL_HOLD)) u_qual (
    .clk(clk), .rst(rst), .lvl(pin_sync), .edge_sel(edge_sel), .evt(evt_w)
  );

  eec_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en_set(en_set), .evt(evt_w),
    .load_val(load_val), .match_val(match_val),
    .count(count_o), .enabled(enabled_o), .hit(hit_w)
  );

  // set has priority over the write-one clear
  assign raw_nxt = hit_w | (raw_match_o & ~irq_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_match_o    <= 1'b0;
      masked_match_o <= 1'b0;
    end else begin
      raw_match_o    <= raw_nxt;
      masked_match_o <= raw_nxt & irq_mask;
    end
  end
endmodule

// File: rtl/eec_checker.sv
module eec_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en_set,
  input logic             irq_clr,
  input logic             evt,
  input logic             hit,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] count_o,
  input logic             enabled_o,
  input logic             raw_match_o,
  input logic             masked_match_o
);
  AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
    (enabled_o && evt && !hit && !en_set) |=> (count_o == CNT_W'($past(count_o) - CNT_W'(1)))); // R4

  AST_ARM_LOAD: assert property (@(posedge clk) disable iff (rst)
    en_set |=> (enabled_o && count_o == $past(load_val))); // R5

  AST_MATCH_STOP: assert property (@(posedge clk) disable iff (rst)
    (hit && !en_set) |=> (!enabled_o && count_o == $past(load_val))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!enabled_o && !en_set) |=> $stable(count_o)); // R7

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
    (raw_match_o && !irq_clr) |=> raw_match_o); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    hit |=> raw_match_o); // R8

  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (rst)
    masked_match_o |-> raw_match_o); // R9
endmodule

bind edge_event_counter eec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en_set(en_set), .irq_clr(irq_clr),
  .evt(evt_w), .hit(hit_w), .load_val(load_val), .count_o(count_o),
  .enabled_o(enabled_o), .raw_match_o(raw_match_o),
  .masked_match_o(masked_match_o)
);

// File: tb/edge_event_counter_tb.sv
module edge_event_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        pin_in;
  logic        en_set;
  logic [1:0]  edge_sel;
  logic [15:0] load_val, match_val;
  logic        irq_mask, irq_clr;
  logic [15:0] count_o;
  logic        enabled_o, raw_match_o, masked_match_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  edge_event_counter u_dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .en_set(en_set),
    .edge_sel(edge_sel), .load_val(load_val), .match_val(match_val),
    .irq_mask(irq_mask), .irq_clr(irq_clr), .count_o(count_o),
    .enabled_o(enabled_o), .raw_match_o(raw_match_o),
    .masked_match_o(masked_match_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: history of pin samples, one per clock
  bit        ph[$];
  int        m_count;
  bit        m_en, m_raw, m_msk;

  always @(posedge clk) begin
    if (rst) begin
      ph = {0, 0, 0, 0, 0};
      m_count = 0; m_en = 0; m_raw = 0; m_msk = 0;
    end else begin
      bit r, f, ev, hit;
      // ph[0] oldest (five samples back), ph[4] newest
      r = !ph[0] && ph[1] && ph[2];
      f = ph[0] && !ph[1] && !ph[2];
      case (edge_sel)
        2'b00:   ev = r;
        2'b01:   ev = f;
        default: ev = r || f;
      endcase
      hit = m_en && ev && (((m_count + 65535) % 65536) == int'(match_val));
      m_raw = hit ? 1'b1 : (irq_clr ? 1'b0 : m_raw);
      m_msk = m_raw && irq_mask;
      if (en_set) begin
        m_count = int'(load_val); m_en = 1;
      end else if (hit) begin
        m_count = int'(load_val); m_en = 0;
      end else if (m_en && ev) begin
        m_count = (m_count + 65535) % 65536;
      end
      void'(ph.pop_front());
      ph.push_back(pin_in);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (int'(count_o) != m_count) begin
        n_bad++; $display("FAIL R4 count: actual %0d expected %0d", count_o, m_count);
      end
      n_chk++;
      if (enabled_o != m_en) begin
        n_bad++; $display("FAIL R6 enabled: actual %0d expected %0d", enabled_o, m_en);
      end
      n_chk++;
      if (raw_match_o != m_raw) begin
        n_bad++; $display("FAIL R8 raw flag: actual %0d expected %0d", raw_match_o, m_raw);
      end
      n_chk++;
      if (masked_match_o != m_msk) begin
        n_bad++; $display("FAIL R9 masked flag: actual %0d expected %0d", masked_match_o, m_msk);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic arm();
    en_set = 1'b1; @(negedge clk); en_set = 1'b0;
  endtask

  task automatic pulse(input int hi, input int lo);
    pin_in = 1'b1; repeat (hi) @(negedge clk);
    pin_in = 1'b0; repeat (lo) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; pin_in = 0; en_set = 0; edge_sel = 2'b00;
    load_val = 0; match_val = 0; irq_mask = 0; irq_clr = 0;
    repeat (4) @(negedge clk);
    chk(int'(count_o), 0, "R1 count");
    chk(int'(enabled_o), 0, "R1 enabled");
    chk(int'(raw_match_o) + int'(masked_match_o), 0, "R1 flags");
    rst = 1'b0;
    @(negedge clk);

    // R7: disarmed after reset, transitions ignored
    pulse(3, 6); pulse(3, 6);
    chk(int'(count_o), 0, "R7 disarmed count");

    // R2 latency, R6 match after load-match events (rising mode)
    load_val = 16'd10; match_val = 16'd7; edge_sel = 2'b00;
    arm();
    pin_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(int'(count_o), 10, "R2 before fifth edge");
    @(negedge clk);
    chk(int'(count_o), 9, "R2 at fifth edge");
    pin_in = 1'b0; repeat (6) @(negedge clk);
    pulse(3, 6);
    chk(int'(count_o), 8, "R4 second event");
    pulse(3, 6);
    chk(int'(enabled_o), 0, "R6 disarmed after match");
    chk(int'(count_o), 10, "R6 reload");
    chk(int'(raw_match_o), 1, "R8 raw set");
    chk(int'(masked_match_o), 0, "R9 masked while mask 0");
    pulse(3, 6);
    chk(int'(count_o), 10, "R7 ignored after match");

    // R9 mask, R8 clear
    irq_mask = 1'b1; @(negedge clk);
    chk(int'(masked_match_o), 1, "R9 mask opens");
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk(int'(raw_match_o), 0, "R8 cleared");
    chk(int'(masked_match_o), 0, "R9 follows clear");

    // R2 glitch rejection and two-cycle acceptance
    match_val = 16'd0;
    arm();
    pulse(1, 6);
    chk(int'(count_o), 10, "R2 one-cycle glitch");
    pulse(2, 6);
    chk(int'(count_o), 9, "R2 two-cycle pulse");

    // R3 edge selection
    edge_sel = 2'b01; pulse(3, 6);
    chk(int'(count_o), 8, "R3 falling only");
    edge_sel = 2'b10; pulse(3, 6);
    chk(int'(count_o), 6, "R3 both 10");
    edge_sel = 2'b11; pulse(3, 6);
    chk(int'(count_o), 4, "R3 both 11");

    // R5 re-arm while armed
    load_val = 16'd30; arm();
    chk(int'(count_o), 30, "R5 reload while armed");

    // R8 set wins over simultaneous clear
    load_val = 16'd5; match_val = 16'd3; edge_sel = 2'b10;
    arm();
    pulse(3, 0);
    irq_clr = 1'b1;
    pin_in = 1'b0;
    for (int i = 0; i < 20 && enabled_o; i++) @(negedge clk);
    chk(int'(raw_match_o), 1, "R8 set wins over clear");
    @(negedge clk);
    chk(int'(raw_match_o), 0, "R8 clear after set");
    irq_clr = 1'b0;
    repeat (4) @(negedge clk);

    // R4 wrap: start 1, match 65534 -> 1,0,65535 then match
    load_val = 16'd1; match_val = 16'd65534; edge_sel = 2'b00;
    arm();
    pulse(3, 6);
    chk(int'(count_o), 0, "R4 step to zero");
    pulse(3, 6);
    chk(int'(count_o), 65535, "R4 wrap");
    pulse(3, 6);
    chk(int'(enabled_o), 0, "R6 match after wrap");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule